// File: doc/BRIEF.md
# Banked Coprocessor Register Access Controller

This block owns a single 32-bit system register that exists as two copies, one for the secure world and one for the non-secure world. It watches coprocessor access requests and acts only on the one encoding assigned to this register. Every matching request passes a fixed-priority chain of checks on the requester's privilege level, the hypervisor trap controls and the secure write locks. The outcome is one of four: the access completes on the banked copy chosen by the security context, an undefined-instruction response, or a trap to the hypervisor. A trap is reported in one of two forms, depending on whether the hypervisor runs in 32-bit or 64-bit state, and it carries a fixed syndrome code.

A request is presented for one cycle. The answer appears on the response port in the following cycle. The core uses the outcome code to retire the instruction, to take an exception, or to route it to the hypervisor. The register's contents are opaque here.

Top module: `cpreg_bank_ctrl`

## Requirements
- R1: After reset, both copies hold zero and no response is valid.
- R2: Only the encoding coprocessor 15, opc1 0, CRn 10, CRm 3, opc2 0 gets a response. Any other encoding gets no response and changes neither copy.
- R3: A request at privilege level 0, read or write, gets outcome UNDEF (code 1) and changes neither copy.
- R4: At level 1, with the hypervisor enabled and the per-register trap input set, the request traps. The outcome is code 2 when the hypervisor is 32-bit and code 3 when it is 64-bit, and the syndrome is 0x03.
- R5: At level 1, with the hypervisor enabled and the per-register trap clear, a read traps only if the read trap input is set, and a write traps only if the write trap input is set. The trap has the same codes and syndrome as in R4, and a trapped write leaves both copies unchanged.
- R6: Trap inputs act only at level 1 with the hypervisor enabled. Accesses at levels 1 and 2 complete with outcome OK (code 0) on the non-secure copy.
- R7: At level 3, the secure-state input selects the copy: 0 selects the secure copy and 1 selects the non-secure copy.
- R8: At level 3 with secure-state 0, a write while either secure lock input is high gets UNDEF and leaves the secure copy unchanged. Reads, and writes with secure-state 1, are unaffected by the locks.
- R9: The response is valid exactly one cycle after a matching request. Read data is zero unless the outcome is OK, and the syndrome is zero unless the outcome is a trap.
- R10: A completed write updates only the selected copy. A later read of that copy returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_cp_i | input | 4 | Coprocessor number |
| req_opc1_i | input | 3 | Opcode 1 field |
| req_crn_i | input | 4 | CRn field |
| req_crm_i | input | 4 | CRm field |
| req_opc2_i | input | 3 | Opcode 2 field |
| req_wdata_i | input | 32 | Write data |
| priv_lvl_i | input | 2 | Current privilege level 0..3 |
| hyp_en_i | input | 1 | Hypervisor level enabled |
| hyp_is32_i | input | 1 | Hypervisor runs 32-bit state |
| top_present_i | input | 1 | Top security level implemented |
| top_is32_i | input | 1 | Top security level runs 32-bit state |
| ns_i | input | 1 | Secure-state bit (1 = non-secure) |
| trap_reg_i | input | 1 | Per-register hypervisor trap |
| trap_vm_rd_i | input | 1 | Hypervisor trap on reads of memory-control registers |
| trap_vm_wr_i | input | 1 | Hypervisor trap on writes of memory-control registers |
| sec_lock_a_i | input | 1 | Secure write lock, first source |
| sec_lock_b_i | input | 1 | Secure write lock, second source |
| rsp_valid_o | output | 1 | Response valid |
| rsp_code_o | output | 2 | 0 OK, 1 UNDEF, 2 hyp trap 32-bit, 3 hyp trap 64-bit |
| rsp_syn_o | output | 8 | Trap syndrome |
| rsp_rdata_o | output | 32 | Read data |

## Verification
A corrupted copy or a write routed to the wrong bank stays hidden until a later read of the affected copy. At that point the port returns data that differs from the last completed write to that copy, or shows that a blocked write landed. The bench therefore reads both copies back after every write, trap and lock scenario. A fault in the check chain shows up in the response one cycle after the request, as a wrong code or syndrome or as nonzero data on a failed access.

// File: rtl/cpreg_pkg.sv
package cpreg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SYN_W  = 8;

  typedef enum logic [1:0] {
    RSP_OK     = 2'd0,
    RSP_UNDEF  = 2'd1,
    RSP_HYP32  = 2'd2,
    RSP_HYP64  = 2'd3
  } rsp_code_e;

  localparam int unsigned BANK_SEC = 0;
  localparam int unsigned BANK_NS  = 1;
endpackage

// File: rtl/cpreg_decode.sv
module cpreg_decode #(
  parameter logic [3:0] MATCH_CP   = 4'd15,
  parameter logic [2:0] MATCH_OPC1 = 3'd0,
  parameter logic [3:0] MATCH_CRN  = 4'd10,
  parameter logic [3:0] MATCH_CRM  = 4'd3,
  parameter logic [2:0] MATCH_OPC2 = 3'd0
) (
  input  logic       valid_i,
  input  logic [3:0] cp_i,
  input  logic [2:0] opc1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] opc2_i,
  output logic       hit_o
);
  logic enc_eq;
  assign enc_eq = (cp_i == MATCH_CP) && (opc1_i == MATCH_OPC1) &&
                  (crn_i == MATCH_CRN) && (crm_i == MATCH_CRM) &&
                  (opc2_i == MATCH_OPC2);
  assign hit_o = valid_i && enc_eq;
endmodule

// File: rtl/cpreg_policy.sv
module cpreg_policy
  import cpreg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned UNBANKED_IDX = BANK_NS,
  parameter logic [SYN_W-1:0] HYP_SYN = 8'h03,
  localparam int unsigned IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             write_i,
  input  logic [1:0]       priv_lvl_i,
  input  logic             hyp_en_i,
  input  logic             hyp_is32_i,
  input  logic             top_present_i,
  input  logic             top_is32_i,
  input  logic             ns_i,
  input  logic             trap_reg_i,
  input  logic             trap_vm_rd_i,
  input  logic             trap_vm_wr_i,
  input  logic             sec_lock_a_i,
  input  logic             sec_lock_b_i,
  output rsp_code_e        code_o,
  output logic [SYN_W-1:0] syn_o,
  output logic [IDX_W-1:0] bank_o
);
  logic       vm_trap;
  logic [IDX_W-1:0] low_bank;
  rsp_code_e  trap_kind;

  assign vm_trap   = write_i ? trap_vm_wr_i : trap_vm_rd_i;
  assign trap_kind = hyp_is32_i ? RSP_HYP32 : RSP_HYP64;
  // levels 1/2: banked non-secure copy with a 32-bit top level, else the unbanked view
  assign low_bank  = (top_present_i && top_is32_i) ? IDX_W'(BANK_NS) : IDX_W'(UNBANKED_IDX);

  always_comb begin
    code_o = RSP_OK;
    bank_o = low_bank;
    unique case (priv_lvl_i)
      2'd0: code_o = RSP_UNDEF;
      2'd1: begin
        if (hyp_en_i && trap_reg_i)   code_o = trap_kind;
        else if (hyp_en_i && vm_trap) code_o = trap_kind;
      end
      2'd2: ;
      default: begin
        bank_o = ns_i ? IDX_W'(BANK_NS) : IDX_W'(BANK_SEC);
        if (!ns_i && write_i && (sec_lock_a_i || sec_lock_b_i)) code_o = RSP_UNDEF;
      end
    endcase
  end

  assign syn_o = (code_o == RSP_HYP32 || code_o == RSP_HYP64) ? HYP_SYN : '0;
endmodule

// File: rtl/cpreg_bank.sv
module cpreg_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            sel_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic [NUM_BANKS*DATA_W-1:0] flat_o
);
  logic [DATA_W-1:0] copy_q [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_copy
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               copy_q[g] <= '0;
      else if (we_i && (sel_i == IDX_W'(g)))     copy_q[g] <= wdata_i;
    end
    assign flat_o[g*DATA_W +: DATA_W] = copy_q[g];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (sel_i == IDX_W'(i)) rdata_o = copy_q[i];
  end
endmodule

// File: rtl/cpreg_bank_ctrl.sv
module cpreg_bank_ctrl
  import cpreg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [3:0]        req_cp_i,
  input  logic [2:0]        req_opc1_i,
  input  logic [3:0]        req_crn_i,
  input  logic [3:0]        req_crm_i,
  input  logic [2:0]        req_opc2_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [1:0]        priv_lvl_i,
  input  logic              hyp_en_i,
  input  logic              hyp_is32_i,
  input  logic              top_present_i,
  input  logic              top_is32_i,
  input  logic              ns_i,
  input  logic              trap_reg_i,
  input  logic              trap_vm_rd_i,
  input  logic              trap_vm_wr_i,
  input  logic              sec_lock_a_i,
  input  logic              sec_lock_b_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_code_o,
  output logic [SYN_W-1:0]  rsp_syn_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  logic                        hit;
  rsp_code_e                   code;
  logic [SYN_W-1:0]            syn;
  logic [IDX_W-1:0]            bank_sel;
  logic [DATA_W-1:0]           bank_rdata;
  logic [NUM_BANKS*DATA_W-1:0] bank_flat;
  logic                        do_write;

  cpreg_decode u_dec (
    .valid_i (req_valid_i),
    .cp_i    (req_cp_i),
    .opc1_i  (req_opc1_i),
    .crn_i   (req_crn_i),
    .crm_i   (req_crm_i),
    .opc2_i  (req_opc2_i),
    .hit_o   (hit)
  );

  cpreg_policy #(.NUM_BANKS(NUM_BANKS)) u_pol (
    .write_i       (req_write_i),
    .priv_lvl_i    (priv_lvl_i),
    .hyp_en_i      (hyp_en_i),
    .hyp_is32_i    (hyp_is32_i),
    .top_present_i (top_present_i),
    .top_is32_i    (top_is32_i),
    .ns_i          (ns_i),
    .trap_reg_i    (trap_reg_i),
    .trap_vm_rd_i  (trap_vm_rd_i),
    .trap_vm_wr_i  (trap_vm_wr_i),
    .sec_lock_a_i  (sec_lock_a_i),
    .sec_lock_b_i  (sec_lock_b_i),
    .code_o        (code),
    .syn_o         (syn),
    .bank_o        (bank_sel)
  );

  assign do_write = hit && req_write_i && (code == RSP_OK);

  cpreg_bank #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (do_write),
    .sel_i   (bank_sel),
    .wdata_i (req_wdata_i),
    .rdata_o (bank_rdata),
    .flat_o  (bank_flat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_code_o  <= RSP_OK;
      rsp_syn_o   <= '0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= hit;
      if (hit) begin
        rsp_code_o  <= code;
        rsp_syn_o   <= syn;
        rsp_rdata_o <= (!req_write_i && code == RSP_OK) ? bank_rdata : '0;
      end
    end
  end
endmodule

// File: rtl/cpreg_bank_ctrl_chk.sv
module cpreg_bank_ctrl_chk
  import cpreg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_write_i,
  input logic [1:0]        priv_lvl_i,
  input logic              ns_i,
  input logic              sec_lock_a_i,
  input logic              sec_lock_b_i,
  input logic              hit,
  input logic              rsp_valid_o,
  input logic [1:0]        rsp_code_o,
  input logic [SYN_W-1:0]  rsp_syn_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic [2*DATA_W-1:0] bank_flat
);
  logic is_trap;
  assign is_trap = (rsp_code_o == RSP_HYP32) || (rsp_code_o == RSP_HYP64);

  a_r9_rsp_follows_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> rsp_valid_o);
  a_r2_no_rsp_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> !rsp_valid_o);
  a_r9_rdata_zero_on_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_code_o != RSP_OK) |-> rsp_rdata_o == '0);
  a_r4_trap_syndrome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && is_trap) |-> rsp_syn_o == 8'h03);
  a_r9_syn_zero_no_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !is_trap) |-> rsp_syn_o == '0);
  a_r3_lvl0_undef: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && priv_lvl_i == 2'd0) |=> rsp_code_o == RSP_UNDEF);
  a_r10_copies_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit && req_write_i) |=> $stable(bank_flat));
  a_r8_locked_secure_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && req_write_i && priv_lvl_i == 2'd3 && !ns_i && (sec_lock_a_i || sec_lock_b_i))
      |=> (rsp_code_o == RSP_UNDEF && $stable(bank_flat[DATA_W-1:0])));
endmodule

bind cpreg_bank_ctrl cpreg_bank_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_write_i  (req_write_i),
  .priv_lvl_i   (priv_lvl_i),
  .ns_i         (ns_i),
  .sec_lock_a_i (sec_lock_a_i),
  .sec_lock_b_i (sec_lock_b_i),
  .hit          (hit),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_code_o   (rsp_code_o),
  .rsp_syn_o    (rsp_syn_o),
  .rsp_rdata_o  (rsp_rdata_o),
  .bank_flat    (bank_flat)
);

// File: tb/sim_cpreg_bank_ctrl.sv
`timescale 1ns/1ps
module sim_cpreg_bank_ctrl;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [3:0] req_cp = 4'd15, req_crn = 4'd10, req_crm = 4'd3;
  logic [2:0] req_opc1 = 3'd0, req_opc2 = 3'd0;
  logic [31:0] req_wdata = 0;
  logic [1:0] priv = 0;
  logic hyp_en = 0, hyp_is32 = 0, top_present = 0, top_is32 = 0, ns = 0;
  logic trap_reg = 0, trap_vm_rd = 0, trap_vm_wr = 0, lock_a = 0, lock_b = 0;
  logic rsp_valid;
  logic [1:0] rsp_code;
  logic [7:0] rsp_syn;
  logic [31:0] rsp_rdata;

  int n_total = 0, n_fail = 0;

  cpreg_bank_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_cp_i(req_cp), .req_opc1_i(req_opc1), .req_crn_i(req_crn), .req_crm_i(req_crm),
    .req_opc2_i(req_opc2), .req_wdata_i(req_wdata), .priv_lvl_i(priv), .hyp_en_i(hyp_en),
    .hyp_is32_i(hyp_is32), .top_present_i(top_present), .top_is32_i(top_is32), .ns_i(ns),
    .trap_reg_i(trap_reg), .trap_vm_rd_i(trap_vm_rd), .trap_vm_wr_i(trap_vm_wr),
    .sec_lock_a_i(lock_a), .sec_lock_b_i(lock_b), .rsp_valid_o(rsp_valid),
    .rsp_code_o(rsp_code), .rsp_syn_o(rsp_syn), .rsp_rdata_o(rsp_rdata));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ctx(input logic [1:0] lvl, input logic n);
    priv = lvl; ns = n; hyp_en = 0; trap_reg = 0; trap_vm_rd = 0; trap_vm_wr = 0;
    lock_a = 0; lock_b = 0;
  endtask

  // one request; response sampled on the next falling edge
  task automatic acc(input logic wr, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic rd_copy(input logic nsel, output logic [31:0] v);
    logic [1:0] sp; logic sn, sh, sa, sb;
    sp = priv; sn = ns; sh = hyp_en; sa = lock_a; sb = lock_b;
    priv = 2'd3; ns = nsel; hyp_en = 0; lock_a = 0; lock_b = 0;
    acc(0, 0);
    v = rsp_rdata;
    priv = sp; ns = sn; hyp_en = sh; lock_a = sa; lock_b = sb;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    rd_copy(0, v); chk("R1 secure copy reset", v, 0);
    rd_copy(1, v); chk("R1 nonsecure copy reset", v, 0);
  endtask

  task automatic t_decode;
    logic [31:0] v;
    ctx(3, 1);
    req_crm = 4'd2; acc(1, 32'hDEAD0001);
    chk("R2 no rsp wrong crm", rsp_valid, 0);
    req_crm = 4'd3; req_cp = 4'd14; acc(1, 32'hDEAD0002);
    chk("R2 no rsp wrong cp", rsp_valid, 0);
    req_cp = 4'd15; req_opc2 = 3'd1; acc(1, 32'hDEAD0003);
    chk("R2 no rsp wrong opc2", rsp_valid, 0);
    req_opc2 = 3'd0;
    rd_copy(1, v); chk("R2 ns copy untouched", v, 0);
    rd_copy(0, v); chk("R2 sec copy untouched", v, 0);
  endtask

  task automatic t_lvl0;
    logic [31:0] v;
    ctx(0, 1);
    acc(1, 32'h11112222);
    chk("R3 write lvl0 valid", rsp_valid, 1);
    chk("R3 write lvl0 undef", rsp_code, 1);
    chk("R9 syn zero on undef", rsp_syn, 0);
    acc(0, 0);
    chk("R3 read lvl0 undef", rsp_code, 1);
    chk("R9 rdata zero on undef", rsp_rdata, 0);
    rd_copy(1, v); chk("R3 ns copy unchanged", v, 0);
  endtask

  task automatic t_banks;
    logic [31:0] v;
    ctx(3, 0); acc(1, 32'hA5A5_0001); chk("R7 sec write ok", rsp_code, 0);
    ctx(3, 1); acc(1, 32'hB6B6_0002); chk("R7 ns write ok", rsp_code, 0);
    rd_copy(0, v); chk("R7 R10 sec copy", v, 32'hA5A5_0001);
    rd_copy(1, v); chk("R7 R10 ns copy", v, 32'hB6B6_0002);
    ctx(1, 0); acc(0, 0);
    chk("R6 lvl1 read ok", rsp_code, 0);
    chk("R6 lvl1 reads ns copy", rsp_rdata, 32'hB6B6_0002);
    ctx(2, 0); top_present = 1; top_is32 = 1;
    acc(1, 32'hC7C7_0003); chk("R6 lvl2 write ok", rsp_code, 0);
    top_present = 0; top_is32 = 0;
    rd_copy(1, v); chk("R10 lvl2 wrote ns copy", v, 32'hC7C7_0003);
    rd_copy(0, v); chk("R10 sec copy kept", v, 32'hA5A5_0001);
    ctx(1, 0); acc(1, 32'hD8D8_0004); chk("R6 lvl1 write ok", rsp_code, 0);
    rd_copy(1, v); chk("R10 lvl1 wrote ns copy", v, 32'hD8D8_0004);
    rd_copy(0, v); chk("R10 sec copy kept again", v, 32'hA5A5_0001);
  endtask

  task automatic t_traps;
    logic [31:0] v;
    ctx(1, 0); hyp_en = 1; trap_reg = 1; hyp_is32 = 1;
    acc(0, 0);
    chk("R4 trap code 32", rsp_code, 2);
    chk("R4 trap syn", rsp_syn, 8'h03);
    chk("R9 rdata zero on trap", rsp_rdata, 0);
    hyp_is32 = 0; acc(1, 32'h0BAD_0001);
    chk("R4 trap code 64", rsp_code, 3);
    chk("R4 trap syn 64", rsp_syn, 8'h03);
    rd_copy(1, v); chk("R4 trapped write no effect", v, 32'hD8D8_0004);
    trap_reg = 0; trap_vm_rd = 1; hyp_is32 = 1;
    acc(0, 0); chk("R5 read trap", rsp_code, 2);
    acc(1, 32'h5555_0001); chk("R5 read trap ignores write", rsp_code, 0);
    trap_vm_rd = 0; trap_vm_wr = 1;
    acc(0, 0); chk("R5 write trap ignores read", rsp_code, 0);
    chk("R5 read data ok", rsp_rdata, 32'h5555_0001);
    acc(1, 32'h0BAD_0002); chk("R5 write trap", rsp_code, 2);
    chk("R5 write trap syn", rsp_syn, 8'h03);
    rd_copy(1, v); chk("R5 trapped write no effect", v, 32'h5555_0001);
    hyp_en = 0; trap_reg = 1; trap_vm_rd = 1;
    acc(0, 0); chk("R6 no traps without hyp", rsp_code, 0);
    ctx(2, 0); trap_reg = 1; trap_vm_rd = 1; trap_vm_wr = 1; hyp_en = 1;
    acc(1, 32'h6666_0001); chk("R6 lvl2 no traps", rsp_code, 0);
    chk("R9 syn zero on ok", rsp_syn, 0);
    rd_copy(1, v); chk("R6 lvl2 write landed", v, 32'h6666_0001);
  endtask

  task automatic t_locks;
    logic [31:0] v;
    ctx(3, 0); lock_a = 1;
    acc(1, 32'h0BAD_0003); chk("R8 lock a write undef", rsp_code, 1);
    lock_a = 0; lock_b = 1;
    acc(1, 32'h0BAD_0004); chk("R8 lock b write undef", rsp_code, 1);
    acc(0, 0); chk("R8 locked read ok", rsp_code, 0);
    chk("R8 locked read data", rsp_rdata, 32'hA5A5_0001);
    rd_copy(0, v); chk("R8 sec copy unchanged", v, 32'hA5A5_0001);
    ns = 1; lock_a = 1;
    acc(1, 32'h7777_0001); chk("R8 ns write unaffected", rsp_code, 0);
    rd_copy(1, v); chk("R8 ns write landed", v, 32'h7777_0001);
    rd_copy(0, v); chk("R10 sec copy kept by ns write", v, 32'hA5A5_0001);
  endtask

  task automatic t_pulse;
    ctx(3, 1);
    acc(0, 0);
    chk("R9 valid one cycle after", rsp_valid, 1);
    @(negedge clk);
    chk("R9 valid drops", rsp_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_decode;
    t_lvl0;
    t_banks;
    t_traps;
    t_locks;
    t_pulse;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule